// File: doc/BRIEF.md
# Fetch-Address Patch Substitution Unit

This block sits between program memory and the instruction decoder of a small CPU. It holds two programmable 24-bit breakpoint addresses. When the CPU fetches an opcode byte from an address that equals an armed breakpoint, the block replaces that byte with a fixed software-interrupt opcode, 01h. The CPU then traps into a patch routine instead of running the original instruction. This lets code in read-only memory be corrected in the field.

Software programs the unit through a byte-wide register bus:

- Each breakpoint is split over three consecutive byte locations, in the order low, middle, high.
- One control byte holds an arm bit for each breakpoint.
- The comparison and the substitution are combinational, so the patched byte appears in the same cycle as the fetch.
- Operand fetches are not altered. They are told apart from opcode fetches by a strobe.

The block has no state machine. Its only states are the stored register contents: after reset the control byte is 00h and both breakpoints are disarmed.

Top module: `fetch_patch_unit`

## Requirements
- R1: After reset the control byte reads 00h and no fetch is substituted, whatever the breakpoint registers contain.
- R2: With control bit 1 set, an opcode fetch (strobe high) whose address equals breakpoint 0 yields `cpu_opcode` = 01h in the same cycle.
- R3: With control bit 3 set, an opcode fetch whose address equals breakpoint 1 yields `cpu_opcode` = 01h in the same cycle.
- R4: A breakpoint whose arm bit is 0 never causes substitution, and `cpu_opcode` equals `mem_opcode`.
- R5: With `fetch_op_strobe` low, `cpu_opcode` equals `mem_opcode` even when the address equals an armed breakpoint.
- R6: When both breakpoints are armed and both equal the fetch address, `cpu_opcode` is 01h.
- R7: Register map:
  - Breakpoint 0 bytes are at 001FF0h (low, bits 7:0), 001FF1h (middle, bits 15:8) and 001FF2h (high, bits 23:16).
  - Breakpoint 1 bytes are at 001FF3h, 001FF4h and 001FF5h, in the same order.
  - The control byte is at 00009Eh.
  - Each location reads back the value last written. Any other address reads 00h.
- R8: Control bits 0, 2, 4, 5, 6 and 7 are stored and read back as written, but have no effect on substitution.
- R9: A register write takes effect at the next rising clock edge. A fetch in the same cycle as the write compares against the old value.
- R10: A fetch address that differs from an armed breakpoint in any single bit is not substituted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 24 | Register bus byte address |
| reg_wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Register write data |
| reg_rd_data | output | 8 | Combinational read data for `reg_addr` |
| fetch_addr | input | 24 | Current CPU fetch address |
| fetch_op_strobe | input | 1 | High when the current fetch is an opcode byte |
| mem_opcode | input | 8 | Byte returned by program memory |
| cpu_opcode | output | 8 | Byte delivered to the CPU decoder |

## Verification
The bench targets the following corner cases:

- **Wrong enable bit.** An enable mapped to the wrong control bit would patch with reserved bits alone, or would fail to patch breakpoint 1.
- **Incomplete compare.** A comparator that drops a byte lane would patch an address one bit away from the breakpoint.
- **Missing strobe gating.** A design that ignores the strobe would corrupt operand bytes.
- **Bad dual hit.** A design that merges hits badly would emit something other than 01h when both breakpoints hit.
- **Write forwarding.** A fetch issued in the same cycle as a breakpoint write must still use the old value. A design that forwarded write data would patch one cycle early.
- **Register map.** Misplaced byte lanes or decode slips show up as readback errors on neighbouring or unmapped addresses.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
    typedef logic [7:0] byte_t;

    // Control-byte bit position that arms detector idx
    function automatic int unsigned arm_bit(input int unsigned idx);
        return 2 * idx + 1;
    endfunction
endpackage

// File: rtl/fpsu_regfile.sv
module fpsu_regfile
    import fpsu_pkg::*;
#(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned NUM_DET   = 2,
    parameter int unsigned BUS_AW    = 24,
    parameter logic [BUS_AW-1:0] DET_BASE  = 24'h001FF0,
    parameter logic [BUS_AW-1:0] CTRL_ADDR = 24'h00009E
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [BUS_AW-1:0]                reg_addr,
    input  logic                             reg_wr_en,
    input  byte_t                            reg_wdata,
    output byte_t                            reg_rd_data,
    output logic [NUM_DET-1:0][ADDR_W-1:0]   det_addr,
    output logic [NUM_DET-1:0]               det_en
);
    localparam int unsigned BPD = (ADDR_W + 7) / 8;

    byte_t              det_q [NUM_DET][BPD];
    logic [BPD*8-1:0]   det_flat [NUM_DET];
    byte_t              ctrl_q;
    logic               ctrl_wr;

    assign ctrl_wr = reg_wr_en && (reg_addr == CTRL_ADDR);

    // Control byte: reset to all zero, every bit stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= reg_wdata;
        end
    end

    // Breakpoint bytes: no reset, one write port per byte slot
    for (genvar d = 0; d < NUM_DET; d++) begin : g_det
        for (genvar b = 0; b < BPD; b++) begin : g_byte
            localparam logic [BUS_AW-1:0] SLOT = BUS_AW'(DET_BASE + d * BPD + b);
            always_ff @(posedge clk) begin
                if (reg_wr_en && (reg_addr == SLOT)) begin
                    det_q[d][b] <= reg_wdata;
                end
            end
            assign det_flat[d][b*8 +: 8] = det_q[d][b];
        end
        assign det_addr[d] = det_flat[d][ADDR_W-1:0];
        assign det_en[d]   = ctrl_q[arm_bit(d)];
    end

    // Combinational readback; unmapped addresses return zero
    always_comb begin
        reg_rd_data = '0;
        if (reg_addr == CTRL_ADDR) begin
            reg_rd_data = ctrl_q;
        end
        for (int d = 0; d < NUM_DET; d++) begin
            for (int b = 0; b < BPD; b++) begin
                if (reg_addr == BUS_AW'(DET_BASE + d * BPD + b)) begin
                    reg_rd_data = det_q[d][b];
                end
            end
        end
    end

    // R7: a control write is visible after the next edge
    p_ctrl_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ctrl_q == $past(reg_wdata));

    // R9: without a control write the control byte holds
    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl_q));

    // R1: control byte is clear when reset releases
    p_reset_ctrl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ctrl_q == 8'h00);
endmodule

// File: rtl/fpsu_match.sv
module fpsu_match #(
    parameter int unsigned ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] det_addr,
    input  logic              det_en,
    input  logic              fetch_op_strobe,
    output logic              hit
);
    assign hit = fetch_op_strobe && det_en && (fetch_addr == det_addr);
endmodule

// File: rtl/fpsu_opmux.sv
module fpsu_opmux
    import fpsu_pkg::*;
#(
    parameter int unsigned NUM_DET  = 2,
    parameter byte_t       PATCH_OP = 8'h01
) (
    input  logic [NUM_DET-1:0] hits,
    input  byte_t              mem_opcode,
    output byte_t              cpu_opcode
);
    // Any number of simultaneous hits collapses to one patch opcode
    assign cpu_opcode = (|hits) ? PATCH_OP : mem_opcode;
endmodule

// File: rtl/fetch_patch_unit.sv
module fetch_patch_unit
    import fpsu_pkg::*;
#(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned NUM_DET   = 2,
    parameter int unsigned BUS_AW    = 24,
    parameter logic [BUS_AW-1:0] DET_BASE  = 24'h001FF0,
    parameter logic [BUS_AW-1:0] CTRL_ADDR = 24'h00009E,
    parameter logic [7:0]        PATCH_OP  = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rd_data,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_op_strobe,
    input  logic [7:0]        mem_opcode,
    output logic [7:0]        cpu_opcode
);
    logic [NUM_DET-1:0][ADDR_W-1:0] det_addr;
    logic [NUM_DET-1:0]             det_en;
    logic [NUM_DET-1:0]             hits;

    fpsu_regfile #(
        .ADDR_W    (ADDR_W),
        .NUM_DET   (NUM_DET),
        .BUS_AW    (BUS_AW),
        .DET_BASE  (DET_BASE),
        .CTRL_ADDR (CTRL_ADDR)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wdata   (reg_wdata),
        .reg_rd_data (reg_rd_data),
        .det_addr    (det_addr),
        .det_en      (det_en)
    );

    for (genvar d = 0; d < NUM_DET; d++) begin : g_cmp
        fpsu_match #(.ADDR_W(ADDR_W)) match_i (
            .fetch_addr      (fetch_addr),
            .det_addr        (det_addr[d]),
            .det_en          (det_en[d]),
            .fetch_op_strobe (fetch_op_strobe),
            .hit             (hits[d])
        );
    end

    fpsu_opmux #(
        .NUM_DET  (NUM_DET),
        .PATCH_OP (PATCH_OP)
    ) mux_i (
        .hits       (hits),
        .mem_opcode (mem_opcode),
        .cpu_opcode (cpu_opcode)
    );

    // R5: operand fetches are never altered
    p_pass_operand_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_op_strobe |-> cpu_opcode == mem_opcode);

    // R2/R6: any comparator hit delivers exactly the patch opcode
    p_patch_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|hits) |-> cpu_opcode == PATCH_OP);

    // R4: with nothing armed the byte passes through
    p_disarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en == '0) |-> cpu_opcode == mem_opcode);

    // R2: the only permitted alteration is the patch opcode on an opcode fetch
    p_only_patch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_opcode != mem_opcode) |-> (fetch_op_strobe && cpu_opcode == PATCH_OP));
endmodule

// File: tb/fetch_patch_unit_tb_top.sv
`timescale 1ns/1ps
module fetch_patch_unit_tb_top;
    localparam logic [23:0] BASE = 24'h001FF0;
    localparam logic [23:0] CTRL = 24'h00009E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rd_data;
    logic [23:0] fetch_addr = '0;
    logic        fetch_op_strobe = 1'b0;
    logic [7:0]  mem_opcode = '0;
    logic [7:0]  cpu_opcode;

    int errs = 0;
    int checks = 0;

    logic [7:0] m_det [2][3];
    logic [7:0] m_ctrl = 8'h00;

    always #2 clk = ~clk;

    fetch_patch_unit dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_addr        (reg_addr),
        .reg_wr_en       (reg_wr_en),
        .reg_wdata       (reg_wdata),
        .reg_rd_data     (reg_rd_data),
        .fetch_addr      (fetch_addr),
        .fetch_op_strobe (fetch_op_strobe),
        .mem_opcode      (mem_opcode),
        .cpu_opcode      (cpu_opcode)
    );

    function automatic logic [23:0] m_bp(input int d);
        return {m_det[d][2], m_det[d][1], m_det[d][0]};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [23:0] a);
        if (a == CTRL) return m_ctrl;
        for (int d = 0; d < 2; d++)
            for (int b = 0; b < 3; b++)
                if (a == BASE + 24'(d * 3 + b)) return m_det[d][b];
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_op(input logic [23:0] a, input logic s, input logic [7:0] mem);
        logic hit0, hit1;
        hit0 = m_ctrl[1] && (a == m_bp(0));
        hit1 = m_ctrl[3] && (a == m_bp(1));
        return (s && (hit0 || hit1)) ? 8'h01 : mem;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a == CTRL) m_ctrl = d;
        for (int i = 0; i < 2; i++)
            for (int b = 0; b < 3; b++)
                if (a == BASE + 24'(i * 3 + b)) m_det[i][b] = d;
    endtask

    task automatic check_read(input logic [23:0] a, input string req);
        @(negedge clk);
        reg_addr = a;
        #1 chk(req, reg_rd_data, exp_rd(a));
    endtask

    task automatic check_fetch(input logic [23:0] a, input logic s, input logic [7:0] mem, input string req);
        @(negedge clk);
        fetch_addr = a; fetch_op_strobe = s; mem_opcode = mem;
        #1 chk(req, cpu_opcode, exp_op(a, s, mem));
    endtask

    task automatic set_bp(input int d, input logic [23:0] v);
        for (int b = 0; b < 3; b++) bus_write(BASE + 24'(d * 3 + b), v[b*8 +: 8]);
    endtask

    initial begin
        #400000;
        errs++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int d = 0; d < 2; d++) for (int b = 0; b < 3; b++) m_det[d][b] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_read(CTRL, "R1 ctrl after reset");
        check_fetch(24'h000000, 1'b1, 8'hA5, "R1 no patch after reset");
        check_fetch(24'h123456, 1'b1, 8'h3C, "R1 no patch after reset");

        // R7: program and read back the map
        set_bp(0, 24'h123456);
        set_bp(1, 24'hABCDEF);
        for (int i = 0; i < 6; i++) check_read(BASE + 24'(i), "R7 breakpoint byte readback");
        check_read(BASE + 24'd6, "R7 unmapped reads zero");
        check_read(CTRL + 24'd1, "R7 unmapped reads zero");

        // R4: disarmed
        check_fetch(24'h123456, 1'b1, 8'hA5, "R4 disarmed bp0");
        check_fetch(24'hABCDEF, 1'b1, 8'hA5, "R4 disarmed bp1");

        // R8: reserved bits stored, no effect
        bus_write(CTRL, 8'hF5);
        check_read(CTRL, "R8 reserved bits readback");
        check_fetch(24'h123456, 1'b1, 8'h5A, "R8 reserved bits do not arm bp0");
        check_fetch(24'hABCDEF, 1'b1, 8'h5A, "R8 reserved bits do not arm bp1");

        // R2 / R10
        bus_write(CTRL, 8'h02);
        check_fetch(24'h123456, 1'b1, 8'h77, "R2 bp0 patch");
        check_fetch(24'hABCDEF, 1'b1, 8'h77, "R4 bp1 still disarmed");
        check_fetch(24'h123457, 1'b1, 8'h77, "R10 low byte differs");
        check_fetch(24'h123556, 1'b1, 8'h77, "R10 middle byte differs");
        check_fetch(24'h923456, 1'b1, 8'h77, "R10 high byte differs");

        // R3
        bus_write(CTRL, 8'h08);
        check_fetch(24'hABCDEF, 1'b1, 8'h77, "R3 bp1 patch");
        check_fetch(24'h123456, 1'b1, 8'h77, "R4 bp0 disarmed");

        // R5
        bus_write(CTRL, 8'h0A);
        check_fetch(24'h123456, 1'b0, 8'h77, "R5 operand fetch passes");
        check_fetch(24'hABCDEF, 1'b0, 8'h88, "R5 operand fetch passes");

        // R6: both hit
        set_bp(1, 24'h123456);
        check_fetch(24'h123456, 1'b1, 8'h99, "R6 dual hit");

        // R9: same-cycle write uses old value
        @(negedge clk);
        fetch_addr = 24'h123456; fetch_op_strobe = 1'b1; mem_opcode = 8'h44;
        bus_write(BASE + 24'd3, 8'h00);
        bus_write(BASE, 8'h57);
        @(negedge clk);
        reg_addr = BASE; reg_wdata = 8'h58; reg_wr_en = 1'b1;
        fetch_addr = 24'h123457; fetch_op_strobe = 1'b1; mem_opcode = 8'h44;
        #1 chk("R9 fetch in write cycle uses old value", cpu_opcode, 8'h01);
        @(negedge clk);
        reg_wr_en = 1'b0;
        m_det[0][0] = 8'h58;
        #1 chk("R9 old value gone after edge", cpu_opcode, 8'h44);
        check_fetch(24'h123458, 1'b1, 8'h44, "R9 new value used after edge");

        // Random phase
        for (int it = 0; it < 4000; it++) begin
            int unsigned sel;
            sel = $urandom % 4;
            if (sel == 0) begin
                int unsigned slot;
                slot = $urandom % 8;
                if (slot == 6) begin
                    bus_write(CTRL, 8'($urandom));
                    check_read(CTRL, "R8 random ctrl readback");
                end else if (slot == 7) begin
                    check_read(24'($urandom), "R7 random address read");
                end else begin
                    bus_write(BASE + 24'(slot), 8'($urandom));
                    check_read(BASE + 24'(slot), "R7 random breakpoint readback");
                end
            end else begin
                logic [23:0] a;
                int unsigned d;
                d = $urandom % 2;
                a = m_bp(d);
                if ($urandom % 3 == 0) a = a ^ (24'd1 << ($urandom % 24));
                check_fetch(a, 1'($urandom % 4 != 0), 8'($urandom | 32'h80),
                            "R2 R3 R10 random fetch");
            end
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule